// File: doc/BRIEF.md
# Paired Event-State Page Controller

This block is a memory-mapped slave that keeps two 2-bit event-state fields for each of a set of queue descriptors. One is a notification pair and the other an escalation pair. Each field holds a P (pending) bit and a Q (queued) bit. Each descriptor owns two adjacent pages. An access to the even page acts on the notification pair. An access to the odd page acts on the escalation pair. The operation is selected by the low 12 bits of the address, not by the data. Loads can end an interrupt, read the state, or overwrite the state. Stores can trigger an event, end an interrupt, or inject an event.

When a store moves a field into a state that calls for delivery, the block raises a one-cycle forward pulse. The pulse carries the descriptor index and a flag naming the pair that was affected, and the routing logic downstream picks it up. A per-descriptor valid vector fences off descriptors that are not configured.

The page size is set by the `PAGE_SHIFT` parameter and must be 12 or 16; any other value stops elaboration. Each request gets a response on the cycle after it is accepted.

Top module: `esb_pair_ctrl`

## Requirements
- R1: After reset every pair of every descriptor reads 00, and no response or forward pulse is raised until a request arrives.
- R2: The descriptor index is address >> (PAGE_SHIFT+1). Address bit PAGE_SHIFT = 0 selects the notification pair and 1 selects the escalation pair, and the two pairs change independently.
- R3: A store at offset 0x000 triggers. With the state written {P,Q}, 00 becomes 10 and raises a forward pulse; 01, 10 and 11 become 11 with no pulse.
- R4: A store at offsets 0x400-0x7FF ends the interrupt. 01 and 11 become 10 and raise a forward pulse; 00 and 10 become 00 with no pulse.
- R5: A load at offsets 0x000-0x7FF applies the same end-of-interrupt transition and returns the notify result in data bit 0, with every other bit zero. It raises no forward pulse.
- R6: A load at offsets 0x800-0xBFF returns the current {P,Q} in data bits [1:0] and leaves the state unchanged.
- R7: A load at offsets 0xC00-0xFFF writes offset bits [9:8] into {P,Q} and returns the previous value in bits [1:0].
- R8: A store at offsets 0x800-0xBFF is an inject. On an even page it raises a forward pulse and leaves the state unchanged. On an odd page it is answered with an error, raises no pulse and changes nothing.
- R9: An access to a descriptor whose valid bit is clear gets an error response and changes no state. For a load the data returned is all ones.
- R10: An access whose size is not 8 bytes gets an error response, raises no pulse and changes no state. For a load the data returned is all ones.
- R11: A store at an offset in 0x001-0x3FF or 0xC00-0xFFF gets an error response and changes no state.
- R12: The response is raised exactly one cycle after each accepted request. A store returns data 0. The forward pulse carries the descriptor index and an escalation flag equal to the page parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_write | input | 1 | 1 for a store, 0 for a load |
| req_addr | input | PAGE_SHIFT+1+IDX_W | Byte address inside the page window |
| req_size | input | 4 | Access size in bytes |
| desc_valid | input | NUM_DESC | Per-descriptor valid bits |
| rsp_valid | output | 1 | Response strobe |
| rsp_data | output | 64 | Load result |
| rsp_err | output | 1 | Access rejected |
| fwd_valid | output | 1 | Forward pulse |
| fwd_index | output | IDX_W | Descriptor index of the pulse |
| fwd_escal | output | 1 | Pulse came from the escalation pair |

## Verification
The main state machine is driven through every start state by chains of triggers and end-of-interrupt operations. Each chain is checked by a state read after every step. This separates an error in the transition from an error in the notify flag. Set loads with all four offset codes check the field position of bits [9:8] and the return of the previous value. The same descriptor is then exercised through its odd page; a mix-up of the pair select shows up as state leaking between pairs. Invalid descriptors, wrong sizes, unassigned offsets and an odd-page inject are each followed by a state read. That read shows the rejected access left nothing behind.

// File: rtl/esb_pair_ctrl.sv
`timescale 1ns/1ps
module esb_pair_ctrl #(
  parameter int NUM_DESC   = 16,
  parameter int PAGE_SHIFT = 12,
  localparam int IDX_W  = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1,
  localparam int ADDR_W = PAGE_SHIFT + 1 + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_size,
  input  logic [NUM_DESC-1:0] desc_valid,
  output logic              rsp_valid,
  output logic [63:0]       rsp_data,
  output logic              rsp_err,
  output logic              fwd_valid,
  output logic [IDX_W-1:0]  fwd_index,
  output logic              fwd_escal
);

  generate
    if (PAGE_SHIFT != 12 && PAGE_SHIFT != 16) begin : g_bad_shift
      $error("esb_pair_ctrl: PAGE_SHIFT must be 12 or 16");
    end
  endgenerate

  logic [1:0] pq_n [NUM_DESC];
  logic [1:0] pq_e [NUM_DESC];

  wire [IDX_W-1:0] idx  = req_addr[ADDR_W-1 -: IDX_W];
  wire             odd  = req_addr[PAGE_SHIFT];
  wire [11:0]      off  = req_addr[11:0];
  wire             hit  = (32'(idx) < NUM_DESC) && desc_valid[idx];
  wire [1:0]       cur  = !hit ? 2'b00 : (odd ? pq_e[idx] : pq_n[idx]);

  wire [1:0] trig_nxt = (cur == 2'b00) ? 2'b10 : 2'b11;
  wire [1:0] eoi_nxt  = cur[0] ? 2'b10 : 2'b00;

  logic [1:0] nxt, ld_val;
  logic       upd, err, fwd;

  always_comb begin
    nxt    = cur;
    ld_val = 2'b00;
    upd    = 1'b0;
    err    = 1'b0;
    fwd    = 1'b0;
    if (req_size != 4'd8 || !hit) begin
      err = 1'b1;
    end else if (req_write) begin
      if (off == 12'h000) begin
        nxt = trig_nxt;
        upd = 1'b1;
        fwd = (cur == 2'b00);
      end else if (off[11:10] == 2'b01) begin
        nxt = eoi_nxt;
        upd = 1'b1;
        fwd = cur[0];
      end else if (off[11:10] == 2'b10) begin
        if (odd) err = 1'b1;
        else     fwd = 1'b1;
      end else begin
        err = 1'b1;
      end
    end else begin
      if (!off[11]) begin
        nxt    = eoi_nxt;
        upd    = 1'b1;
        ld_val = {1'b0, cur[0]};
      end else if (!off[10]) begin
        ld_val = cur;
      end else begin
        nxt    = off[9:8];
        upd    = 1'b1;
        ld_val = cur;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_DESC; i++) begin
        pq_n[i] <= 2'b00;
        pq_e[i] <= 2'b00;
      end
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_err   <= 1'b0;
      fwd_valid <= 1'b0;
      fwd_index <= '0;
      fwd_escal <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      fwd_valid <= req_valid && fwd;
      if (req_valid) begin
        if (upd) begin
          if (odd) pq_e[idx] <= nxt;
          else     pq_n[idx] <= nxt;
        end
        rsp_err   <= err;
        rsp_data  <= (err && !req_write) ? {64{1'b1}} : {62'b0, ld_val};
        fwd_index <= idx;
        fwd_escal <= odd;
      end
    end
  end

endmodule

// File: rtl/esb_pair_ctrl_chk.sv
`timescale 1ns/1ps
module esb_pair_ctrl_chk #(
  parameter int NUM_DESC   = 16,
  parameter int PAGE_SHIFT = 12,
  localparam int IDX_W  = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1,
  localparam int ADDR_W = PAGE_SHIFT + 1 + IDX_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [3:0]        req_size,
  input logic              rsp_valid,
  input logic [63:0]       rsp_data,
  input logic              rsp_err,
  input logic              fwd_valid
);

  // R12
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R12
  quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid && !fwd_valid);

  // R5
  load_never_forwards_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_write |=> !fwd_valid);

  // R10
  bad_size_rejected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_size != 4'd8 |=> rsp_err && !fwd_valid);

  // R8
  odd_inject_rejected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write && req_addr[PAGE_SHIFT] && req_addr[11:10] == 2'b10
    |=> rsp_err && !fwd_valid);

  // R9
  bad_load_all_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_write |=> !rsp_err || rsp_data == {64{1'b1}});

endmodule

bind esb_pair_ctrl esb_pair_ctrl_chk #(.NUM_DESC(NUM_DESC), .PAGE_SHIFT(PAGE_SHIFT)) chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_size(req_size), .rsp_valid(rsp_valid),
  .rsp_data(rsp_data), .rsp_err(rsp_err), .fwd_valid(fwd_valid)
);

// File: tb/esb_pair_ctrl_test.sv
`timescale 1ns/1ps
module esb_pair_ctrl_test;
  localparam int ND = 16;
  localparam int PS = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [3:0] req_size = 4'd8;
  logic [ND-1:0] desc_valid = 16'hFFDF;
  logic rsp_valid, rsp_err, fwd_valid, fwd_escal;
  logic [63:0] rsp_data;
  logic [3:0] fwd_index;

  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  esb_pair_ctrl #(.NUM_DESC(ND), .PAGE_SHIFT(PS)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .desc_valid(desc_valid),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .fwd_valid(fwd_valid), .fwd_index(fwd_index), .fwd_escal(fwd_escal));

  // fields: req(4) wr(1) desc(4) odd(1) off(12) exp(2) ones(1) err(1) fwd(1)
  localparam int NV = 31;
  localparam logic [26:0] VEC [NV] = '{
    {4'd3,  1'b1, 4'd2, 1'b0, 12'h000, 2'd0, 1'b0, 1'b0, 1'b1}, // R3 00->10
    {4'd3,  1'b1, 4'd2, 1'b0, 12'h000, 2'd0, 1'b0, 1'b0, 1'b0}, // R3 10->11
    {4'd6,  1'b0, 4'd2, 1'b0, 12'h800, 2'd3, 1'b0, 1'b0, 1'b0}, // R6
    {4'd4,  1'b1, 4'd2, 1'b0, 12'h400, 2'd0, 1'b0, 1'b0, 1'b1}, // R4 11->10
    {4'd6,  1'b0, 4'd2, 1'b0, 12'h900, 2'd2, 1'b0, 1'b0, 1'b0}, // R6
    {4'd5,  1'b0, 4'd2, 1'b0, 12'h000, 2'd0, 1'b0, 1'b0, 1'b0}, // R5 10->00
    {4'd6,  1'b0, 4'd2, 1'b0, 12'h800, 2'd0, 1'b0, 1'b0, 1'b0}, // R6
    {4'd7,  1'b0, 4'd2, 1'b0, 12'hD00, 2'd0, 1'b0, 1'b0, 1'b0}, // R7 set 01
    {4'd7,  1'b0, 4'd2, 1'b0, 12'h800, 2'd1, 1'b0, 1'b0, 1'b0}, // R7
    {4'd3,  1'b1, 4'd2, 1'b0, 12'h000, 2'd0, 1'b0, 1'b0, 1'b0}, // R3 01->11
    {4'd5,  1'b0, 4'd2, 1'b0, 12'h7F8, 2'd1, 1'b0, 1'b0, 1'b0}, // R5 11->10
    {4'd5,  1'b0, 4'd2, 1'b0, 12'h800, 2'd2, 1'b0, 1'b0, 1'b0}, // R5
    {4'd2,  1'b0, 4'd2, 1'b1, 12'h800, 2'd0, 1'b0, 1'b0, 1'b0}, // R2 odd untouched
    {4'd2,  1'b1, 4'd2, 1'b1, 12'h000, 2'd0, 1'b0, 1'b0, 1'b1}, // R2 odd trigger
    {4'd2,  1'b0, 4'd2, 1'b1, 12'h800, 2'd2, 1'b0, 1'b0, 1'b0}, // R2
    {4'd8,  1'b1, 4'd2, 1'b1, 12'h800, 2'd0, 1'b0, 1'b1, 1'b0}, // R8 odd inject
    {4'd8,  1'b0, 4'd2, 1'b1, 12'h800, 2'd2, 1'b0, 1'b0, 1'b0}, // R8
    {4'd8,  1'b1, 4'd2, 1'b0, 12'hA00, 2'd0, 1'b0, 1'b0, 1'b1}, // R8 even inject
    {4'd8,  1'b0, 4'd2, 1'b0, 12'h800, 2'd2, 1'b0, 1'b0, 1'b0}, // R8
    {4'd9,  1'b1, 4'd5, 1'b0, 12'h000, 2'd0, 1'b0, 1'b1, 1'b0}, // R9
    {4'd9,  1'b0, 4'd5, 1'b0, 12'h800, 2'd0, 1'b1, 1'b1, 1'b0}, // R9
    {4'd7,  1'b0, 4'd3, 1'b0, 12'hF00, 2'd0, 1'b0, 1'b0, 1'b0}, // R7 set 11
    {4'd7,  1'b0, 4'd3, 1'b0, 12'h800, 2'd3, 1'b0, 1'b0, 1'b0}, // R7
    {4'd7,  1'b0, 4'd3, 1'b0, 12'hE00, 2'd3, 1'b0, 1'b0, 1'b0}, // R7 set 10
    {4'd7,  1'b0, 4'd3, 1'b0, 12'h800, 2'd2, 1'b0, 1'b0, 1'b0}, // R7
    {4'd7,  1'b0, 4'd3, 1'b0, 12'hC00, 2'd2, 1'b0, 1'b0, 1'b0}, // R7 set 00
    {4'd7,  1'b0, 4'd3, 1'b0, 12'h800, 2'd0, 1'b0, 1'b0, 1'b0}, // R7
    {4'd11, 1'b1, 4'd3, 1'b0, 12'h010, 2'd0, 1'b0, 1'b1, 1'b0}, // R11
    {4'd11, 1'b1, 4'd3, 1'b0, 12'hC00, 2'd0, 1'b0, 1'b1, 1'b0}, // R11
    {4'd4,  1'b1, 4'd3, 1'b0, 12'h400, 2'd0, 1'b0, 1'b0, 1'b0}, // R4 00 stays
    {4'd11, 1'b0, 4'd3, 1'b0, 12'h800, 2'd0, 1'b0, 1'b0, 1'b0}  // R11 no change
  };

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input bit wr, input int d, input bit odd, input logic [11:0] off, input logic [3:0] sz);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = {d[3:0], odd, off};
    req_size  = sz;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_rsp(input string tag, input logic [63:0] d, input bit e, input bit f,
                            input int di, input bit odd);
    logic [63:0] got, want;
    got  = {rsp_data[63:2], rsp_data[1:0]};
    want = d;
    check(rsp_valid === 1'b1, {tag, " rsp_valid"}, {63'b0, rsp_valid}, 64'd1);
    check(got === want, {tag, " data"}, got, want);
    check(rsp_err === e, {tag, " err"}, {63'b0, rsp_err}, {63'b0, e});
    check(fwd_valid === f, {tag, " fwd"}, {63'b0, fwd_valid}, {63'b0, f});
    if (f && fwd_valid)
      check(fwd_index == di[3:0] && fwd_escal == odd, {tag, " fwd tag"},
            {59'b0, fwd_escal, fwd_index}, {59'b0, odd, di[3:0]});
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(rsp_valid === 1'b0 && fwd_valid === 1'b0, "R1 idle after reset",
          {62'b0, rsp_valid, fwd_valid}, 64'd0);
    xfer(1'b0, 0, 1'b0, 12'h800, 4'd8);
    expect_rsp("R1 even reads 00", 64'd0, 1'b0, 1'b0, 0, 1'b0);
    xfer(1'b0, 15, 1'b1, 12'h800, 4'd8);
    expect_rsp("R1 odd reads 00", 64'd0, 1'b0, 1'b0, 15, 1'b1);

    for (int i = 0; i < NV; i++) begin
      logic [26:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d vec%0d", v[26:23], i);
      xfer(v[22], int'(v[21:18]), v[17], v[16:5], 4'd8);
      expect_rsp(tag, v[2] ? {64{1'b1}} : {62'b0, v[4:3]}, v[1], v[0], int'(v[21:18]), v[17]);
    end

    // R10 wrong size store then load
    xfer(1'b1, 4, 1'b0, 12'h000, 4'd4);
    expect_rsp("R10 short store", 64'd0, 1'b1, 1'b0, 4, 1'b0);
    xfer(1'b0, 4, 1'b0, 12'hF00, 4'd4);
    expect_rsp("R10 short load", {64{1'b1}}, 1'b1, 1'b0, 4, 1'b0);
    xfer(1'b0, 4, 1'b0, 12'h800, 4'd8);
    expect_rsp("R10 state kept", 64'd0, 1'b0, 1'b0, 4, 1'b0);

    // R12 back-to-back triggers on two descriptors, checked per cycle
    req_valid = 1'b1; req_write = 1'b1; req_size = 4'd8;
    req_addr = {4'd7, 1'b1, 12'h000};
    @(negedge clk);
    expect_rsp("R12 first pulse", 64'd0, 1'b0, 1'b1, 7, 1'b1);
    req_addr = {4'd9, 1'b0, 12'h000};
    @(negedge clk);
    req_valid = 1'b0;
    expect_rsp("R12 second pulse", 64'd0, 1'b0, 1'b1, 9, 1'b0);
    @(negedge clk);
    check(rsp_valid === 1'b0 && fwd_valid === 1'b0, "R12 idle gap",
          {62'b0, rsp_valid, fwd_valid}, 64'd0);

    // R9 descriptor re-validated keeps its untouched 00 state
    desc_valid = '1;
    xfer(1'b0, 5, 1'b0, 12'h800, 4'd8);
    expect_rsp("R9 invalid access left no state", 64'd0, 1'b0, 1'b0, 5, 1'b0);

    // R1 reset clears a set field
    xfer(1'b1, 6, 1'b0, 12'h000, 4'd8);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    xfer(1'b0, 6, 1'b0, 12'h800, 4'd8);
    expect_rsp("R1 reset clears state", 64'd0, 1'b0, 1'b0, 6, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule